// File: doc/BRIEF.md
# Serial Byte Transmitter with Pin Override

This block turns a stream of bytes into an asynchronous serial line. Bytes arrive on a ready/valid handshake; each accepted byte is framed as a low start bit, the data bits least significant first, an optional parity bit (even or odd), and one high stop bit. Every bit lasts one period of an external baud tick. That tick is a single-cycle pulse from a phase accumulator outside this block. Between characters the line rests high.

The final pin level is chosen by a priority selector. A software-forced level has the highest priority. Line loopback comes next and echoes the incoming receive line onto the pin. System loopback is next and holds the pin high while the serialized bits are routed internally to the receiver. The serializer has the lowest priority. A second output gives the receiver its view of the line, so that both loopback modes can be exercised without an external wire.

Top module: `uart_tx`

## Requirements
- R1: While rst_ni is low, and after its release until a byte is accepted, tx_o is 1, busy_o is 0 and ready_o is 0 whenever tx_en_i is 0.
- R2: A byte is accepted (ready_o high) only in a cycle where tick_i is 1, tx_en_i is 1 and no character is in flight. Therefore ready_o is never 1 while busy_o is 1 or tick_i is 0.
- R3: An accepted byte is sent as serializer bits 0 (start), data[0] through data[7], [parity], 1 (stop). The first bit starts on the clock edge that accepts the byte. Each later bit starts on the next edge where tick_i is 1, and every bit holds between those edges. busy_o is 1 for the whole frame.
- R4: With parity enabled, the bit after data[7] is the XOR of the data bits, inverted when odd parity is selected. Without parity, the stop bit follows data[7] directly. The parity enable and the odd select are sampled when the byte is accepted; changes during the frame have no effect on it.
- R5: After the stop bit, busy_o falls on the next tick edge. The serializer output stays 1 for at least one full tick period before the next start bit.
- R6: idle_o is 1 exactly when busy_o is 0 and valid_i is 0.
- R7: When ovrd_en_i is 1, tx_o equals ovrd_val_i, regardless of serializer state and of both loopback controls.
- R8: With sys_lpbk_i at 1, line_lpbk_i at 0 and no override, tx_o is 1 and rx_core_o carries the serializer bit.
- R9: With line_lpbk_i at 1 and no override, tx_o follows rx_i and rx_core_o is 1. This holds whatever sys_lpbk_i is. With neither loopback on, rx_core_o follows rx_i.
- R10: If tx_en_i falls during a frame, that frame still completes unchanged. Afterwards no byte is accepted while tx_en_i stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Allows new bytes to be accepted |
| parity_en_i | input | 1 | Adds a parity bit to the frame |
| parity_odd_i | input | 1 | 1 selects odd parity, 0 even |
| sys_lpbk_i | input | 1 | Routes serializer to receiver, pin forced high |
| line_lpbk_i | input | 1 | Echoes rx_i onto the pin |
| ovrd_en_i | input | 1 | Forces the pin to ovrd_val_i |
| ovrd_val_i | input | 1 | Forced pin level |
| tick_i | input | 1 | One-cycle baud pulse |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | data_i is offered |
| ready_o | output | 1 | Byte accepted this cycle when valid_i is 1 |
| rx_i | input | 1 | Raw receive line |
| tx_o | output | 1 | Transmit pin level |
| rx_core_o | output | 1 | Line level seen by the receiver |
| busy_o | output | 1 | A character is in flight |
| idle_o | output | 1 | Nothing pending and nothing in flight |

## Verification
Every one of the 256 byte values is sent under three parity settings: none, even and odd. This separates bit order, frame length and parity polarity, and a swapped, dropped or inverted bit shows up for some value. A few frames change the parity controls or drop the enable right after acceptance, which tells sampled configuration apart from live configuration. Shorter runs repeat framing under each loopback and override combination while the receive line toggles every cycle. This shows which source reaches the pin and which reaches the receiver, and it shows the priority among them.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    SRC_SER  = 2'd0,
    SRC_OVRD = 2'd1,
    SRC_HIGH = 2'd2,
    SRC_RX   = 2'd3
  } pin_src_e;
endpackage

// File: rtl/uart_tx_ser.sv
module uart_tx_ser #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              tick_i,
  input  logic              parity_en_i,
  input  logic              parity_odd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              ser_bit_o,
  output logic              busy_o
);
  localparam int FRAME_MAX = DATA_W + 3;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  logic [FRAME_MAX-1:0] shreg_q;
  logic [CNT_W-1:0]     left_q;
  logic                 busy;
  logic                 load;
  logic                 par_bit;

  assign busy    = (left_q != '0);
  assign ready_o = tx_en_i & tick_i & ~busy;
  assign load    = ready_o & valid_i;
  assign par_bit = (^data_i) ^ parity_odd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '1;
      left_q  <= '0;
    end else if (load) begin
      // stop, parity-or-stop, data, start
      shreg_q <= {1'b1, (parity_en_i ? par_bit : 1'b1), data_i, 1'b0};
      left_q  <= parity_en_i ? CNT_W'(FRAME_MAX) : CNT_W'(FRAME_MAX - 1);
    end else if (busy && tick_i) begin
      shreg_q <= {1'b1, shreg_q[FRAME_MAX-1:1]};
      left_q  <= left_q - 1'b1;
    end
  end

  assign ser_bit_o = busy ? shreg_q[0] : 1'b1;
  assign busy_o    = busy;

  AST_START_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(tick_i && tx_en_i && valid_i)); // R2

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy) && !$past(tick_i)) |-> $stable(ser_bit_o)); // R3

  AST_STOP_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> $past(ser_bit_o)); // R3

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !ser_bit_o); // R3

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= CNT_W'(FRAME_MAX)); // R3
endmodule

// File: rtl/uart_tx_pinmux.sv
module uart_tx_pinmux
  import uart_tx_pkg::*;
(
  input  logic ser_bit_i,
  input  logic rx_i,
  input  logic ovrd_en_i,
  input  logic ovrd_val_i,
  input  logic sys_lpbk_i,
  input  logic line_lpbk_i,
  output logic tx_o,
  output logic rx_core_o
);
  pin_src_e src;

  always_comb begin
    if (ovrd_en_i)        src = SRC_OVRD;
    else if (line_lpbk_i) src = SRC_RX;
    else if (sys_lpbk_i)  src = SRC_HIGH;
    else                  src = SRC_SER;
  end

  always_comb begin
    unique case (src)
      SRC_OVRD: tx_o = ovrd_val_i;
      SRC_RX:   tx_o = rx_i;
      SRC_HIGH: tx_o = 1'b1;
      default:  tx_o = ser_bit_i;
    endcase
  end

  // receiver sees idle line under line loopback
  always_comb begin
    if (line_lpbk_i)     rx_core_o = 1'b1;
    else if (sys_lpbk_i) rx_core_o = ser_bit_i;
    else                 rx_core_o = rx_i;
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              parity_en_i,
  input  logic              parity_odd_i,
  input  logic              sys_lpbk_i,
  input  logic              line_lpbk_i,
  input  logic              ovrd_en_i,
  input  logic              ovrd_val_i,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              rx_i,
  output logic              tx_o,
  output logic              rx_core_o,
  output logic              busy_o,
  output logic              idle_o
);
  logic ser_bit;
  logic busy;

  uart_tx_ser #(.DATA_W(DATA_W)) u_ser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tx_en_i      (tx_en_i),
    .tick_i       (tick_i),
    .parity_en_i  (parity_en_i),
    .parity_odd_i (parity_odd_i),
    .data_i       (data_i),
    .valid_i      (valid_i),
    .ready_o      (ready_o),
    .ser_bit_o    (ser_bit),
    .busy_o       (busy)
  );

  uart_tx_pinmux u_pinmux (
    .ser_bit_i   (ser_bit),
    .rx_i        (rx_i),
    .ovrd_en_i   (ovrd_en_i),
    .ovrd_val_i  (ovrd_val_i),
    .sys_lpbk_i  (sys_lpbk_i),
    .line_lpbk_i (line_lpbk_i),
    .tx_o        (tx_o),
    .rx_core_o   (rx_core_o)
  );

  assign busy_o = busy;
  assign idle_o = ~busy & ~valid_i;

  AST_OVRD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovrd_en_i |-> (tx_o == ovrd_val_i)); // R7

  AST_SYS_LPBK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_lpbk_i && !line_lpbk_i && !ovrd_en_i) |-> (tx_o && rx_core_o == ser_bit)); // R8

  AST_LINE_LPBK_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_lpbk_i && !ovrd_en_i) |-> (tx_o == rx_i && rx_core_o)); // R9

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !ready_o); // R2

  AST_DISABLED_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(tx_en_i) && !$past(busy)) |-> !busy); // R10
endmodule

// File: tb/uart_tx_tb.sv
module uart_tx_tb;
  localparam int DW   = 8;
  localparam int TDIV = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni = 1'b0;
  logic tx_en_i = 1'b0, parity_en_i = 1'b0, parity_odd_i = 1'b0;
  logic sys_lpbk_i = 1'b0, line_lpbk_i = 1'b0, ovrd_en_i = 1'b0, ovrd_val_i = 1'b0;
  logic tick_i = 1'b0, valid_i = 1'b0, rx_i = 1'b1;
  logic [DW-1:0] data_i = '0;
  logic ready_o, tx_o, rx_core_o, busy_o, idle_o;

  int total = 0;
  int bad = 0;
  int tick_cnt = 0;

  uart_tx #(.DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .parity_en_i(parity_en_i),
    .parity_odd_i(parity_odd_i), .sys_lpbk_i(sys_lpbk_i), .line_lpbk_i(line_lpbk_i),
    .ovrd_en_i(ovrd_en_i), .ovrd_val_i(ovrd_val_i), .tick_i(tick_i), .data_i(data_i),
    .valid_i(valid_i), .ready_o(ready_o), .rx_i(rx_i), .tx_o(tx_o),
    .rx_core_o(rx_core_o), .busy_o(busy_o), .idle_o(idle_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    tick_cnt = (tick_cnt + 1) % TDIV;
    tick_i   = (tick_cnt == 0);
    rx_i     = tick_cnt[0];
    #1;
  endtask

  function automatic logic pin_exp(input logic b);
    if (ovrd_en_i)   return ovrd_val_i;
    if (line_lpbk_i) return rx_i;
    if (sys_lpbk_i)  return 1'b1;
    return b;
  endfunction

  function automatic logic rxc_exp(input logic b);
    if (line_lpbk_i) return 1'b1;
    if (sys_lpbk_i)  return b;
    return rx_i;
  endfunction

  task automatic send(input logic [7:0] d, input bit pen, input bit podd,
                      input bit flip, input bit dis_mid);
    logic [10:0] bits;
    int n;
    int guard;
    logic t;
    parity_en_i = pen; parity_odd_i = podd; data_i = d; valid_i = 1'b1;
    #1;
    guard = 0;
    while (!ready_o && guard < 100) begin
      // R5 line high while waiting, R6 pending data
      chk(busy_o == 1'b0 && tx_o == pin_exp(1'b1), "R5 idle line", {busy_o, tx_o}, {1'b0, pin_exp(1'b1)});
      chk(idle_o == 1'b0, "R6 pending", idle_o, 0);
      chk(!ready_o || tick_i, "R2 ready off-tick", ready_o, 0);
      cyc();
      guard++;
    end
    chk(tick_i == 1'b1, "R2 ready on tick", tick_i, 1);
    cyc();
    valid_i = 1'b0; data_i = ~d;
    if (flip) begin parity_en_i = ~pen; parity_odd_i = ~podd; end
    if (dis_mid) tx_en_i = 1'b0;
    #1;
    bits = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[1+i] = d[i];
    if (pen) begin bits[9] = (^d) ^ podd; n = 11; end
    else n = 10;
    for (int b = 0; b < n; b++) begin
      do begin
        chk(busy_o == 1'b1, "R3 busy", busy_o, 1);
        chk(ready_o == 1'b0, "R2 no ready busy", ready_o, 0);
        chk(tx_o == pin_exp(bits[b]), pen ? "R4 R3 R7 R8 R9 pin" : "R3 R7 R8 R9 pin",
            tx_o, pin_exp(bits[b]));
        chk(rx_core_o == rxc_exp(bits[b]), "R8 R9 rx_core", rx_core_o, rxc_exp(bits[b]));
        t = tick_i;
        cyc();
      end while (!t);
    end
    chk(busy_o == 1'b0, "R5 busy done", busy_o, 0);
    chk(tx_o == pin_exp(1'b1), "R5 line high", tx_o, pin_exp(1'b1));
    chk(idle_o == 1'b1, "R6 idle", idle_o, 1);
    if (dis_mid) begin
      valid_i = 1'b1;
      repeat (3 * TDIV) begin
        #1;
        chk(ready_o == 1'b0 && busy_o == 1'b0, "R10 no accept", {ready_o, busy_o}, 0);
        chk(idle_o == 1'b0, "R6 pending", idle_o, 0);
        cyc();
      end
      valid_i = 1'b0; #1;
      chk(idle_o == 1'b1, "R6 idle", idle_o, 1);
      tx_en_i = 1'b1;
    end
  endtask

  initial begin
    repeat (3) cyc();
    chk(tx_o == 1'b1, "R1 reset pin", tx_o, 1);
    chk(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
    chk(idle_o == 1'b1, "R1 reset idle", idle_o, 1);
    rst_ni = 1'b1;
    valid_i = 1'b1; data_i = 8'h55;
    repeat (3 * TDIV) begin
      chk(ready_o == 1'b0 && busy_o == 1'b0 && tx_o == 1'b1, "R1 R10 disabled",
          {ready_o, busy_o, tx_o}, 3'b001);
      cyc();
    end
    valid_i = 1'b0;
    ovrd_en_i = 1'b1;
    for (int v = 0; v < 2; v++) begin
      ovrd_val_i = v[0]; sys_lpbk_i = v[0]; line_lpbk_i = ~v[0]; #1;
      chk(tx_o == v[0], "R7 override idle", tx_o, v);
    end
    ovrd_en_i = 1'b0; sys_lpbk_i = 1'b0; line_lpbk_i = 1'b0;
    tx_en_i = 1'b1;
    for (int d = 0; d < 256; d++)
      for (int c = 0; c < 3; c++)
        send(8'(d), c != 0, c == 2, 1'b0, 1'b0);
    // R4 parity sampled at accept
    send(8'hA5, 1'b1, 1'b0, 1'b1, 1'b0);
    send(8'h3C, 1'b0, 1'b1, 1'b1, 1'b0);
    send(8'h96, 1'b1, 1'b1, 1'b1, 1'b0);
    // R10 disable mid-frame
    send(8'h5A, 1'b1, 1'b1, 1'b0, 1'b1);
    send(8'hC3, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int m = 1; m < 6; m++) begin
      sys_lpbk_i  = (m == 1 || m == 3 || m == 4);
      line_lpbk_i = (m == 2 || m == 3 || m == 5);
      ovrd_en_i   = (m >= 4);
      ovrd_val_i  = (m == 5);
      for (int k = 0; k < 8; k++)
        send(8'(k * 37 + m), k[0], k[1], 1'b0, 1'b0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R3 watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule